// File: doc/BRIEF.md
# Text Dot Generator with Computed Inverse Video

This block turns character codes held in a local 2 KB character memory into a serial one-bit dot stream for an 80-column text display. The host fills the character memory through its own write port. An external raster timing unit drives a character strobe once per character cell. With each strobe it supplies the cell's memory address, the current glyph scan row, a display-enable flag and a cursor flag. For each strobe the block reads the code from memory and then reads one row of the glyph from a font table. It applies a single inversion mask and shifts the seven visible dots out, first dot first, one per clock.

The font table stores only the 128 normal glyphs. A code with bit 7 set is drawn as the exact complement of the glyph for its low seven bits. The cursor uses the same complement operation. The mask is code bit 7 exclusive-or the cursor flag, so a cursor over an inverse character shows it in normal video. The display-enable and cursor flags travel down the pipeline with the data, so each flag applies to the character whose strobe it was sampled with.

Top module: `text_pixel_gen`

## Requirements
- R1: While reset is high, and on the first clock after it, `pix` and `pix_valid` are 0.
- R2: A byte written through the host port at an address is the code rendered when a later strobe presents that address. The memory holds 2048 bytes, and the whole address range from 0 to 2047 can be used.
- R3: For a code c below 128 and a row r from 0 to 8, the seven dots equal c[6:0] rotated left by (r mod 7) positions. The dots come out bit 6 first and bit 0 last. This is a computed placeholder font.
- R4: Rows 9 to 15 of every glyph are blank before masking. A normal code there gives seven 0 dots, and a code of 128 or above gives seven 1 dots.
- R5: A code of 128 or above shows the bitwise complement of the dots of code minus 128, on the same row.
- R6: When the cursor flag is high with the strobe, the seven dots are complemented. On a code of 128 or above the two inversions cancel and the normal glyph is shown.
- R7: When display-enable is low with the strobe, all seven dots are 0, whatever the code and cursor flag.
- R8: The first dot of a character appears on `pix` in the clock after the second rising edge that follows the strobe edge. `pix_valid` stays low until then.
- R9: `pix_valid` is high for exactly seven clocks per strobe. Strobes spaced seven clocks apart give an unbroken valid run. When no further strobe follows, `pix_valid` and `pix` drop back to 0.
- R10: Display-enable and cursor are sampled only on the strobe edge. Changing them in the following clock does not change that character's dots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe for the character memory |
| host_addr | input | 11 | Host write address |
| host_wdata | input | 8 | Host write data (character code) |
| char_stb | input | 1 | One-clock pulse per character cell |
| char_addr | input | 11 | Character memory address of the cell |
| row_idx | input | 4 | Glyph scan row, 0 to 15 |
| disp_en | input | 1 | Active display area flag |
| cursor_on | input | 1 | Cursor covers this cell |
| pix | output | 1 | Serial dot, first dot first |
| pix_valid | output | 1 | High while `pix` carries a dot |

## Verification
Single characters are rendered with normal codes on several rows, including the last active row 8. These separate a correct font lookup from a wrong row or column order. The same codes are repeated with bit 7 set and on rows 9 and above, which shows that inversion is applied after the blank-row rule and not before it. Cursor cases on normal and inverse codes, a blanked cell with every other input set, and flags toggled right after the strobe show whether the mask and the blanking use the values sampled with the strobe. Two strobes spaced seven clocks apart, followed by silence, expose any gap or overrun in the valid window.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  // Placeholder font: active rows rotate the low seven code bits left by
  // (row mod 7); rows at or past active_rows are blank.
  function automatic logic [6:0] glyph_row(input int code7, input int row,
                                           input int active_rows);
    logic [6:0]  v;
    logic [13:0] w;
    int          r;
    if (row >= active_rows) return 7'h00;
    r = row % 7;
    v = 7'(code7);
    w = {v, v} >> (7 - r);
    return w[6:0];
  endfunction

endpackage

// File: rtl/tpg_char_ram.sv
module tpg_char_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/tpg_glyph_rom.sv
module tpg_glyph_rom
  import tpg_pkg::*;
#(
  parameter int CODE_W      = 7,
  parameter int ROW_W       = 4,
  parameter int DOTS        = 7,
  parameter int ACTIVE_ROWS = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [CODE_W-1:0] code,
  input  logic [ROW_W-1:0]  row,
  output logic [DOTS-1:0]   q
);
  localparam int ADDR_W = CODE_W + ROW_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int ROWS   = 1 << ROW_W;

  logic [DOTS-1:0] rom [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = DOTS'(glyph_row(i / ROWS, i % ROWS, ACTIVE_ROWS));
  end

  always_ff @(posedge clk) begin
    if (rd_en) q <= rom[{code, row}];
  end

  // Rows past the active font height read back blank.
  assert_blank_rows_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && (int'(row) >= ACTIVE_ROWS)) |=> (q == '0));
endmodule

// File: rtl/tpg_dot_shifter.sv
module tpg_dot_shifter #(
  parameter int DOTS      = 7,
  parameter bit MSB_FIRST = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [DOTS-1:0] pattern,
  output logic            pix,
  output logic            pix_valid
);
  localparam int CNT_W = $clog2(DOTS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DOTS - 1);

  logic [DOTS-1:0]  sh;
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      remain    <= '0;
      pix_valid <= 1'b0;
    end else if (load) begin
      sh        <= pattern;
      remain    <= LAST;
      pix_valid <= 1'b1;
    end else if (remain != '0) begin
      sh        <= MSB_FIRST ? (sh << 1) : (sh >> 1);
      remain    <= remain - 1'b1;
    end else begin
      sh        <= '0;
      pix_valid <= 1'b0;
    end
  end

  generate
    if (MSB_FIRST) begin : g_msb
      assign pix = sh[DOTS-1];
    end else begin : g_lsb
      assign pix = sh[0];
    end
  endgenerate

  assert_load_valid_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> pix_valid);

  assert_idle_dark_R9: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> !pix);
endmodule

// File: rtl/text_pixel_gen.sv
module text_pixel_gen #(
  parameter int ADDR_W      = 11,
  parameter int CODE_W      = 8,
  parameter int ROW_W       = 4,
  parameter int DOTS        = 7,
  parameter int ACTIVE_ROWS = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [CODE_W-1:0] host_wdata,
  input  logic              char_stb,
  input  logic [ADDR_W-1:0] char_addr,
  input  logic [ROW_W-1:0]  row_idx,
  input  logic              disp_en,
  input  logic              cursor_on,
  output logic              pix,
  output logic              pix_valid
);
  localparam int GLYPH_W = CODE_W - 1;

  // stage 1: character memory read in flight
  logic              s1_vld, s1_de, s1_cur;
  logic [ROW_W-1:0]  s1_row;
  logic [CODE_W-1:0] code_q;
  // stage 2: glyph row read in flight
  logic              s2_vld, s2_de, s2_cur, s2_inv;
  logic [DOTS-1:0]   glyph_q;
  logic [DOTS-1:0]   dots;

  tpg_char_ram #(.ADDR_W(ADDR_W), .DATA_W(CODE_W)) u_ram (
    .clk     (clk),
    .wr_en   (host_we),
    .wr_addr (host_addr),
    .wr_data (host_wdata),
    .rd_en   (char_stb),
    .rd_addr (char_addr),
    .rd_data (code_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_de  <= 1'b0;
      s1_cur <= 1'b0;
      s1_row <= '0;
      s2_vld <= 1'b0;
      s2_de  <= 1'b0;
      s2_cur <= 1'b0;
      s2_inv <= 1'b0;
    end else begin
      s1_vld <= char_stb;
      if (char_stb) begin
        s1_de  <= disp_en;
        s1_cur <= cursor_on;
        s1_row <= row_idx;
      end
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_de  <= s1_de;
        s2_cur <= s1_cur;
        s2_inv <= code_q[CODE_W-1];
      end
    end
  end

  tpg_glyph_rom #(
    .CODE_W      (GLYPH_W),
    .ROW_W       (ROW_W),
    .DOTS        (DOTS),
    .ACTIVE_ROWS (ACTIVE_ROWS)
  ) u_rom (
    .clk   (clk),
    .rst   (rst),
    .rd_en (s1_vld),
    .code  (code_q[GLYPH_W-1:0]),
    .row   (s1_row),
    .q     (glyph_q)
  );

  // One mask covers both inverse codes and the cursor; blanking wins.
  always_comb begin
    dots = glyph_q ^ {DOTS{s2_inv ^ s2_cur}};
    if (!s2_de) dots = '0;
  end

  tpg_dot_shifter #(.DOTS(DOTS), .MSB_FIRST(1'b1)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (s2_vld),
    .pattern   (dots),
    .pix       (pix),
    .pix_valid (pix_valid)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!pix && !pix_valid));

  assert_blank_cell_R7: assert property (@(posedge clk) disable iff (rst)
    (char_stb && !disp_en) |-> ##3 !pix);

  assert_strobe_valid_R9: assert property (@(posedge clk) disable iff (rst)
    char_stb |-> ##3 pix_valid);
endmodule

// File: tb/test_text_pixel_gen.sv
module test_text_pixel_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        host_we;
  logic [10:0] host_addr;
  logic [7:0]  host_wdata;
  logic        char_stb;
  logic [10:0] char_addr;
  logic [3:0]  row_idx;
  logic        disp_en;
  logic        cursor_on;
  logic        pix, pix_valid;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  text_pixel_gen i_text_pixel_gen (
    .clk, .rst, .host_we, .host_addr, .host_wdata, .char_stb, .char_addr,
    .row_idx, .disp_en, .cursor_on, .pix, .pix_valid
  );

  function automatic logic [6:0] expect_dots(input logic [7:0] c, input int r,
                                             input bit de, input bit cur);
    logic [13:0] w;
    logic [6:0]  base;
    if (!de) return 7'h00;
    if (r >= 9) base = 7'h00;
    else begin
      w    = {c[6:0], c[6:0]} >> (7 - (r % 7));
      base = w[6:0];
    end
    return base ^ {7{c[7] ^ cur}};
  endfunction

  task automatic check(input logic [13:0] got, input logic [13:0] exp,
                       input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic host_write(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  // One isolated character; flip toggles the flags in the clock after the strobe.
  task automatic render(input logic [10:0] a, input logic [7:0] code,
                        input int r, input bit de, input bit cur,
                        input bit flip, input string req);
    logic [6:0] got;
    bit         all_valid = 1'b1;
    @(negedge clk);
    char_stb = 1'b1; char_addr = a; row_idx = 4'(r);
    disp_en = de; cursor_on = cur;
    @(negedge clk);
    char_stb = 1'b0;
    if (flip) begin disp_en = ~de; cursor_on = ~cur; end
    @(negedge clk);
    check({13'd0, pix_valid}, 14'd0, {req, " R8 valid before first dot"});
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      got[6-k] = pix;
      all_valid &= pix_valid;
    end
    check({7'd0, got}, {7'd0, expect_dots(code, r, de, cur)}, req);
    check({13'd0, all_valid}, 14'd1, {req, " R9 valid over 7 dots"});
    @(negedge clk);
    check({12'd0, pix_valid, pix}, 14'd0, {req, " R9 idle after character"});
    disp_en = 1'b1; cursor_on = 1'b0;
  endtask

  task automatic stream_two(input logic [10:0] a0, input logic [7:0] c0,
                            input logic [10:0] a1, input logic [7:0] c1,
                            input int r);
    logic [13:0] got;
    bit          all_valid = 1'b1;
    @(negedge clk);
    char_stb = 1'b1; char_addr = a0; row_idx = 4'(r);
    disp_en = 1'b1; cursor_on = 1'b0;
    for (int c = 1; c <= 17; c++) begin
      @(negedge clk);
      if (c == 1 || c == 8) char_stb = 1'b0;
      if (c == 7) begin char_stb = 1'b1; char_addr = a1; end
      if (c >= 3 && c <= 16) begin
        got[16-c] = pix;
        all_valid &= pix_valid;
      end
      if (c == 17)
        check({12'd0, pix_valid, pix}, 14'd0, "R9 idle after stream");
    end
    check(got, {expect_dots(c0, r, 1, 0), expect_dots(c1, r, 1, 0)},
          "R9 back-to-back dots");
    check({13'd0, all_valid}, 14'd1, "R9 unbroken valid run");
  endtask

  initial begin
    #(20ns * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    char_stb = 1'b0; char_addr = '0; row_idx = '0; disp_en = 1'b1; cursor_on = 1'b0;
    repeat (3) @(negedge clk);
    check({12'd0, pix_valid, pix}, 14'd0, "R1 outputs in reset");
    rst = 1'b0;
    @(negedge clk);
    check({12'd0, pix_valid, pix}, 14'd0, "R1 outputs after reset");

    host_write(11'h000, 8'h41);
    host_write(11'h001, 8'hC1);
    host_write(11'h7FF, 8'h5A);
    host_write(11'h123, 8'h33);
    host_write(11'h124, 8'hB3);
    host_write(11'h200, 8'hFF);

    render(11'h000, 8'h41, 0, 1, 0, 0, "R3 code 41 row 0");
    render(11'h000, 8'h41, 2, 1, 0, 0, "R3 code 41 row 2");
    render(11'h7FF, 8'h5A, 8, 1, 0, 0, "R2 R3 top address row 8");
    render(11'h123, 8'h33, 9, 1, 0, 0, "R4 normal code row 9");
    render(11'h124, 8'hB3, 15, 1, 0, 0, "R4 inverse code row 15");
    render(11'h001, 8'hC1, 2, 1, 0, 0, "R5 inverse of 41 row 2");
    render(11'h000, 8'h41, 2, 1, 1, 0, "R6 cursor on normal");
    render(11'h001, 8'hC1, 2, 1, 1, 0, "R6 cursor on inverse");
    render(11'h200, 8'hFF, 3, 0, 1, 0, "R7 blanked cell");
    render(11'h000, 8'h41, 5, 1, 0, 1, "R10 flags toggled after strobe");
    render(11'h200, 8'hFF, 4, 0, 0, 1, "R10 blank held after strobe");

    host_write(11'h000, 8'h2C);
    render(11'h000, 8'h2C, 1, 1, 0, 0, "R2 overwritten code");

    stream_two(11'h7FF, 8'h5A, 11'h001, 8'hC1, 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule